// File: doc/BRIEF.md
# Gated Interval Timer Pair

Two down-counting interval timers share one interrupt source and one interrupt-enable bit. Each timer counts ticks from either a free-running internal time base or the rising edges of its own external pulse input. Its external gate input can also bound the counting to a gate window. A timer reports underflow, the end of a gate window, or both, as a three-bit condition code. The request is presented on a valid/ready pair together with the index of the timer that raised it.

Software drives the block through a single-cycle register write port. The port selects a register kind and a timer index. The kinds are the enable bit, a start/stop command, the count value, the reload value and the mode bits. Each timer's count and run state are brought out as plain status pins. Three reset classes each clear a different set of state. Power-on reset is asynchronous and active low. System reset and device reset are synchronous, active-high pulses.

Back-pressure rules for the request interface: `irq_valid` stays high and `irq_src` stays fixed until a cycle with `irq_ready` high accepts the request. A device reset or system reset is the only exception. A newer event from the same timer may still upgrade `irq_code` before acceptance, so the consumer takes the code present in the accepting cycle. Only one request is presented at a time. Other timers wait in their own slot.

Top module: `gated_interval_timer`

## Requirements
- R1: On power-on reset both counters and both reload registers become all ones, both timers are stopped, the enable bit is cleared and no request is pending.
- R2: A running timer decrements by one per tick. A loaded value N underflows on the (N+1)th tick. Mode bit 1 clear selects the internal tick, one every TB_DIV cycles, so the first request after a start comes between N*TB_DIV and (N+1)*TB_DIV cycles later. Mode bit 1 set selects the synchronised rising edge of the timer's ext_pulse bit.
- R3: An underflow that is not part of a completed gate window raises code 3 with irq_src set to the timer index. Without reload, the counter becomes all ones. The timer stops unless gating (mode bit 2) is on, in which case it keeps counting.
- R4: With mode bit 0 set, an underflow loads the counter from the reload register on the same tick and the timer keeps running.
- R5: A command write (kind 1) starts timer i with data bit i and stops it with data bit N_TMR+i. A start is ignored while the enable bit (kind 0, data bit 0) is clear.
- R6: With gating on, a running timer counts only inside a window. The window opens on a synchronised rising edge of its ext_gate bit and closes on the next falling edge. That falling edge completes the cycle, stops the timer, and raises code 4 if no underflow happened in the window.
- R7: A window in which an underflow happened earlier, or that closes in the same cycle as an underflow, raises code 7 at completion. The same-cycle case produces only that one request.
- R8: A window that completes without underflow while the same timer's earlier request is still unaccepted raises code 6, which replaces the pending code.
- R9: Only codes 3, 4, 6 and 7 are presented. The lowest pending timer index is presented first. Valid and source hold until accepted, and acceptance clears that request.
- R10: Device reset stops both timers and clears mode bits and all pending requests. Counter values, reload values and the enable bit are kept.
- R11: System reset does what device reset does and also clears the enable bit. Counter and reload values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System reset pulse, synchronous |
| dev_rst | input | 1 | Device reset / halt pulse, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | 0 enable, 1 command, 2 count, 3 reload, 4 mode |
| wr_idx | input | IW | Timer index for kinds 2 to 4 |
| wr_data | input | CNT_W | Write data |
| ext_pulse | input | N_TMR | External tick inputs, one per timer, asynchronous |
| ext_gate | input | N_TMR | External gate inputs, one per timer, asynchronous |
| irq_valid | output | 1 | Request present |
| irq_ready | input | 1 | Request accepted when high with irq_valid |
| irq_code | output | 3 | Condition code of the presented request |
| irq_src | output | IW | Timer index of the presented request |
| cnt_o | output | N_TMR*CNT_W | Counter values, timer i at bits [i*CNT_W +: CNT_W] |
| run_o | output | N_TMR | Run state per timer |

## Verification
The bound checker checks the request handshake on every cycle: codes stay within the legal set, and valid and source hold until acceptance. It also checks that no timer enters the run state unless the enable bit was set, and the immediate effects of device and system reset on run state, requests, counters and the enable bit. The decrement arithmetic, the N versus N+1 tick timing, reload values, and the choice among codes 3, 4, 6 and 7 cannot be checked that way. They depend on tick and gate histories, so only the bench scenarios show them. Those scenarios are random tick counts against a bench model, gate windows with and without an earlier underflow, a window closing on the same tick as an underflow, and power-on reload values.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  typedef enum logic [2:0] {
    CC_NONE     = 3'd0,
    CC_DEV_END  = 3'd3,
    CC_ATTN     = 3'd4,
    CC_ATTN_EXC = 3'd6,
    CC_ATTN_DE  = 3'd7
  } cc_e;

  typedef enum logic [2:0] {
    WK_ENABLE = 3'd0,
    WK_CMD    = 3'd1,
    WK_COUNT  = 3'd2,
    WK_RELOAD = 3'd3,
    WK_MODE   = 3'd4
  } wkind_e;

  localparam int MODE_W    = 3;
  localparam int MB_RELOAD = 0;
  localparam int MB_EXT    = 1;
  localparam int MB_GATE   = 2;
endpackage

// File: rtl/gtm_sync.sv
// Two-stage synchroniser plus one delay stage for edge detection.
module gtm_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] lvl_d_o
);
  logic [WIDTH-1:0] meta_q, sync_q, dly_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= '0;
      sync_q <= '0;
      dly_q  <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign lvl_o   = sync_q;
  assign lvl_d_o = dly_q;
endmodule

// File: rtl/gtm_timebase.sv
// Free-running divider producing a one-cycle tick every TB_DIV cycles.
module gtm_timebase #(
  parameter int TB_DIV = 4
) (
  input  logic clk,
  input  logic por_n,
  output logic tick_o
);
  localparam int PW = (TB_DIV > 2) ? $clog2(TB_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TB_DIV - 1);

  logic [PW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/gtm_channel.sv
// One timer: counter, reload register, mode bits, run state and gate window.
module gtm_channel
  import gtm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         soft_clr,
  input  logic         tick_int,
  input  logic         pulse_rise,
  input  logic         gate_rise,
  input  logic         gate_fall,
  input  logic         ld_cnt,
  input  logic         ld_reload,
  input  logic         ld_mode,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         stop,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         evt_valid,
  output cc_e          evt_code
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0]      cnt_q, reload_q;
  logic [MODE_W-1:0] mode_q;
  logic              run_q, in_win_q, uf_seen_q;
  logic              tick, cnt_en, underflow, win_done;

  always_comb begin
    tick      = mode_q[MB_EXT] ? pulse_rise : tick_int;
    cnt_en    = run_q && tick && (!mode_q[MB_GATE] || in_win_q);
    underflow = cnt_en && (cnt_q == '0);
    win_done  = run_q && mode_q[MB_GATE] && in_win_q && gate_fall;
    evt_valid = underflow || win_done;
    if (win_done)       evt_code = (underflow || uf_seen_q) ? CC_ATTN_DE : CC_ATTN;
    else if (underflow) evt_code = CC_DEV_END;
    else                evt_code = CC_NONE;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q     <= ONES;
      reload_q  <= ONES;
      mode_q    <= '0;
      run_q     <= 1'b0;
      in_win_q  <= 1'b0;
      uf_seen_q <= 1'b0;
    end else if (soft_clr) begin
      mode_q    <= '0;
      run_q     <= 1'b0;
      in_win_q  <= 1'b0;
      uf_seen_q <= 1'b0;
    end else begin
      if (ld_reload) reload_q <= wr_data;
      if (ld_mode)   mode_q   <= wr_data[MODE_W-1:0];

      if (ld_cnt)      cnt_q <= wr_data;
      else if (cnt_en) cnt_q <= underflow ? (mode_q[MB_RELOAD] ? reload_q : ONES)
                                          : cnt_q - W'(1);

      if (stop || win_done ||
          (underflow && !mode_q[MB_RELOAD] && !mode_q[MB_GATE]))
        run_q <= 1'b0;
      else if (start)
        run_q <= 1'b1;

      if (start || stop || win_done || !run_q)
        in_win_q <= 1'b0;
      else if (mode_q[MB_GATE] && gate_rise)
        in_win_q <= 1'b1;

      if (start || win_done || !run_q)
        uf_seen_q <= 1'b0;
      else if (underflow && in_win_q)
        uf_seen_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/gtm_irq_arb.sv
// One request slot per timer, fixed priority to the lowest index,
// presented source held until accepted.
module gtm_irq_arb
  import gtm_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic [N-1:0]  evt_valid,
  input  cc_e           evt_code [N],
  output logic          irq_valid,
  input  logic          irq_ready,
  output logic [2:0]    irq_code,
  output logic [IW-1:0] irq_src
);
  logic [N-1:0]  pend;
  cc_e           codes [N];
  logic          hold_q;
  logic [IW-1:0] hold_idx_q, sel;
  logic          accept;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) sel = IW'(i);
    end
    if (hold_q) sel = hold_idx_q;
  end

  assign irq_valid = |pend;
  assign irq_code  = codes[sel];
  assign irq_src   = sel;
  assign accept    = irq_valid && irq_ready;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic p_q;
    cc_e  c_q;
    logic ack, busy;

    assign ack  = accept && (sel == IW'(g));
    assign busy = p_q && !ack;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        p_q <= 1'b0;
        c_q <= CC_NONE;
      end else if (clr) begin
        p_q <= 1'b0;
      end else if (evt_valid[g]) begin
        p_q <= 1'b1;
        c_q <= (evt_code[g] == CC_ATTN && busy) ? CC_ATTN_EXC : evt_code[g];
      end else if (ack) begin
        p_q <= 1'b0;
      end
    end

    assign pend[g]  = p_q;
    assign codes[g] = c_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (clr) begin
      hold_q     <= 1'b0;
    end else begin
      hold_q     <= irq_valid && !irq_ready;
      hold_idx_q <= sel;
    end
  end
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer
  import gtm_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 16,
  parameter int TB_DIV = 4,
  parameter int IW     = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   sys_rst,
  input  logic                   dev_rst,
  input  logic                   wr_en,
  input  logic [2:0]             wr_kind,
  input  logic [IW-1:0]          wr_idx,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic [N_TMR-1:0]       ext_pulse,
  input  logic [N_TMR-1:0]       ext_gate,
  output logic                   irq_valid,
  input  logic                   irq_ready,
  output logic [2:0]             irq_code,
  output logic [IW-1:0]          irq_src,
  output logic [N_TMR*CNT_W-1:0] cnt_o,
  output logic [N_TMR-1:0]       run_o
);
  logic               soft_clr, wr_ok, prep_en_q, tick_int;
  logic [N_TMR-1:0]   start_v, stop_v, evt_valid;
  logic [N_TMR-1:0]   g_lvl, g_dly, p_lvl, p_dly;
  cc_e                evt_code [N_TMR];

  assign soft_clr = dev_rst || sys_rst;
  assign wr_ok    = wr_en && !soft_clr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                             prep_en_q <= 1'b0;
    else if (sys_rst)                       prep_en_q <= 1'b0;
    else if (wr_ok && wr_kind == WK_ENABLE) prep_en_q <= wr_data[0];
  end

  assign start_v = (wr_ok && wr_kind == WK_CMD && prep_en_q) ? wr_data[N_TMR-1:0] : '0;
  assign stop_v  = (wr_ok && wr_kind == WK_CMD) ? wr_data[2*N_TMR-1:N_TMR] : '0;

  gtm_timebase #(.TB_DIV(TB_DIV)) u_tb (
    .clk(clk), .por_n(por_n), .tick_o(tick_int)
  );

  gtm_sync #(.WIDTH(2*N_TMR)) u_sync (
    .clk(clk), .por_n(por_n),
    .async_i({ext_gate, ext_pulse}),
    .lvl_o({g_lvl, p_lvl}),
    .lvl_d_o({g_dly, p_dly})
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic sel_me;
    assign sel_me = wr_ok && (wr_idx == IW'(g));

    gtm_channel #(.W(CNT_W)) u_ch (
      .clk        (clk),
      .por_n      (por_n),
      .soft_clr   (soft_clr),
      .tick_int   (tick_int),
      .pulse_rise (p_lvl[g] && !p_dly[g]),
      .gate_rise  (g_lvl[g] && !g_dly[g]),
      .gate_fall  (!g_lvl[g] && g_dly[g]),
      .ld_cnt     (sel_me && wr_kind == WK_COUNT),
      .ld_reload  (sel_me && wr_kind == WK_RELOAD),
      .ld_mode    (sel_me && wr_kind == WK_MODE),
      .wr_data    (wr_data),
      .start      (start_v[g]),
      .stop       (stop_v[g]),
      .cnt_o      (cnt_o[g*CNT_W +: CNT_W]),
      .run_o      (run_o[g]),
      .evt_valid  (evt_valid[g]),
      .evt_code   (evt_code[g])
    );
  end

  gtm_irq_arb #(.N(N_TMR), .IW(IW)) u_arb (
    .clk       (clk),
    .por_n     (por_n),
    .clr       (soft_clr),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .irq_valid (irq_valid),
    .irq_ready (irq_ready),
    .irq_code  (irq_code),
    .irq_src   (irq_src)
  );
endmodule

// File: rtl/gated_interval_timer_chk.sv
module gated_interval_timer_chk #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 16,
  parameter int IW    = 1
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   sys_rst,
  input logic                   dev_rst,
  input logic                   irq_valid,
  input logic                   irq_ready,
  input logic [2:0]             irq_code,
  input logic [IW-1:0]          irq_src,
  input logic [N_TMR*CNT_W-1:0] cnt_o,
  input logic [N_TMR-1:0]       run_o,
  input logic                   prep_en
);
  // R9
  hold_until_accept_chk: assert property (@(posedge clk) disable iff (!por_n)
    (irq_valid && !irq_ready && !dev_rst && !sys_rst) |=> (irq_valid && $stable(irq_src)));

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (!por_n)
    irq_valid |-> (irq_code inside {3'd3, 3'd4, 3'd6, 3'd7}));

  // R5
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    (|(run_o & ~$past(run_o))) |-> $past(prep_en));

  // R10
  dev_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
    dev_rst |=> (run_o == '0 && !irq_valid));

  // R10
  dev_keep_cnt_chk: assert property (@(posedge clk) disable iff (!por_n)
    dev_rst |=> $stable(cnt_o));

  // R11
  sys_clear_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !prep_en);

  // R11
  sys_keep_cnt_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> ($stable(cnt_o) && run_o == '0));
endmodule

bind gated_interval_timer gated_interval_timer_chk #(
  .N_TMR(N_TMR), .CNT_W(CNT_W), .IW(IW)
) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .dev_rst(dev_rst),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_code(irq_code),
  .irq_src(irq_src), .cnt_o(cnt_o), .run_o(run_o), .prep_en(prep_en_q)
);

// File: tb/test_gated_interval_timer.sv
module test_gated_interval_timer;
  localparam int CLK_P = 10;
  localparam int N     = 2;
  localparam int W     = 16;
  localparam int DIV   = 4;

  logic           clk = 1'b0;
  logic           por_n, sys_rst, dev_rst, wr_en, irq_ready;
  logic [2:0]     wr_kind;
  logic [0:0]     wr_idx;
  logic [W-1:0]   wr_data;
  logic [N-1:0]   ext_pulse, ext_gate, run_o;
  logic           irq_valid;
  logic [2:0]     irq_code;
  logic [0:0]     irq_src;
  logic [N*W-1:0] cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gated_interval_timer #(.N_TMR(N), .CNT_W(W), .TB_DIV(DIV)) i_gated_interval_timer (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .dev_rst(dev_rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .ext_pulse(ext_pulse), .ext_gate(ext_gate),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_code(irq_code),
    .irq_src(irq_src), .cnt_o(cnt_o), .run_o(run_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt_of(input int i);
    return 32'(cnt_o[i*W +: W]);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] k, input int idx, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = 1'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); ext_pulse = m;
    cyc(4); ext_pulse = '0;
    cyc(4);
  endtask

  task automatic gate(input logic [N-1:0] m, input bit lvl);
    @(negedge clk);
    if (lvl) ext_gate = ext_gate | m; else ext_gate = ext_gate & ~m;
    cyc(6);
  endtask

  task automatic ack();
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic dreset();
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
  endtask

  // Bench model of the counter after k external ticks in non-gated mode.
  function automatic void model(input int n, input int k, input bit rl, input int rv,
                                output int c, output bit run, output int ufs);
    c = n; run = 1'b1; ufs = 0;
    for (int t = 0; t < k; t++) begin
      if (run) begin
        if (c == 0) begin
          ufs++;
          if (rl) c = rv;
          else begin c = 32'hFFFF; run = 1'b0; end
        end else c--;
      end
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, k, rv, c, ufs, idx;
    bit rl, run;
    logic [31:0] held;
    void'($urandom(32'd4321));
    por_n = 1'b0; sys_rst = 1'b0; dev_rst = 1'b0; wr_en = 1'b0; irq_ready = 1'b0;
    wr_kind = '0; wr_idx = '0; wr_data = '0; ext_pulse = '0; ext_gate = '0;
    cyc(3); por_n = 1'b1; cyc(2);

    // R1 reset state
    chk("R1 cnt0", cnt_of(0), 32'hFFFF);
    chk("R1 cnt1", cnt_of(1), 32'hFFFF);
    chk("R1 run", 32'(run_o), 0);
    chk("R1 irq", 32'(irq_valid), 0);

    // R5 start ignored with enable clear
    wr(3'd1, 0, 16'h0003); cyc(2);
    chk("R5 start ignored", 32'(run_o), 0);
    wr(3'd0, 0, 16'h0001);

    // R2 internal tick timing window, R3 non-reload stop
    wr(3'd2, 0, 16'd3);
    wr(3'd1, 0, 16'h0001);
    cyc(3 * DIV);
    chk("R2 no request before N periods", 32'(irq_valid), 0);
    cyc(DIV);
    chk("R2 request by N+1 periods", 32'(irq_valid), 1);
    chk("R3 code", 32'(irq_code), 3);
    chk("R3 src", 32'(irq_src), 0);
    chk("R3 stopped", 32'(run_o[0]), 0);
    chk("R3 all ones", cnt_of(0), 32'hFFFF);
    ack();
    chk("R9 ack clears", 32'(irq_valid), 0);

    // R2 R3 R4 random external tick runs against the bench model
    for (int it = 0; it < 24; it++) begin
      idx = $urandom_range(0, 1);
      n   = $urandom_range(0, 5);
      k   = $urandom_range(0, n + 4);
      rl  = 1'($urandom_range(0, 1));
      rv  = $urandom_range(0, 4);
      dreset();
      wr(3'd4, idx, rl ? 16'h0003 : 16'h0002);
      wr(3'd3, idx, 16'(rv));
      wr(3'd2, idx, 16'(n));
      wr(3'd1, 0, 16'(1 << idx));
      for (int p = 0; p < k; p++) pulse(2'(1 << idx));
      model(n, k, rl, rv, c, run, ufs);
      chk(rl ? "R4 cnt reload" : "R2 cnt", cnt_of(idx), 32'(c));
      chk(rl ? "R4 run" : "R3 run", 32'(run_o[idx]), 32'(run));
      chk("R3 irq pending", 32'(irq_valid), (ufs > 0) ? 1 : 0);
      if (ufs > 0) begin
        chk("R3 code rnd", 32'(irq_code), 3);
        chk("R3 src rnd", 32'(irq_src), 32'(idx));
        ack();
      end
    end

    // R9 priority: both timers underflow together
    dreset();
    wr(3'd4, 0, 16'h0002); wr(3'd4, 1, 16'h0002);
    wr(3'd2, 0, 16'd0);    wr(3'd2, 1, 16'd0);
    wr(3'd1, 0, 16'h0003);
    pulse(2'b11);
    chk("R9 both valid", 32'(irq_valid), 1);
    chk("R9 lowest first", 32'(irq_src), 0);
    cyc(3);
    chk("R9 src held", 32'(irq_src), 0);
    ack();
    chk("R9 second valid", 32'(irq_valid), 1);
    chk("R9 second src", 32'(irq_src), 1);
    ack();
    chk("R9 drained", 32'(irq_valid), 0);

    // R6 gate window, code 4, then R8 code 6 with request unaccepted
    dreset();
    wr(3'd4, 1, 16'h0006);
    wr(3'd2, 1, 16'd5);
    wr(3'd1, 0, 16'h0002);
    pulse(2'b10);
    chk("R6 no count outside window", cnt_of(1), 5);
    gate(2'b10, 1'b1);
    pulse(2'b10); pulse(2'b10);
    chk("R6 counts in window", cnt_of(1), 3);
    chk("R6 no early request", 32'(irq_valid), 0);
    gate(2'b10, 1'b0);
    chk("R6 valid", 32'(irq_valid), 1);
    chk("R6 code 4", 32'(irq_code), 4);
    chk("R6 src", 32'(irq_src), 1);
    chk("R6 run cleared", 32'(run_o[1]), 0);
    wr(3'd1, 0, 16'h0002);
    gate(2'b10, 1'b1);
    pulse(2'b10);
    gate(2'b10, 1'b0);
    chk("R8 code 6", 32'(irq_code), 6);
    ack();
    chk("R8 cleared", 32'(irq_valid), 0);

    // R7 underflow earlier in the window
    dreset();
    wr(3'd4, 1, 16'h0006);
    wr(3'd2, 1, 16'd1);
    wr(3'd1, 0, 16'h0002);
    gate(2'b10, 1'b1);
    pulse(2'b10); pulse(2'b10);
    chk("R3 gated underflow code", 32'(irq_code), 3);
    chk("R3 gated keeps running", 32'(run_o[1]), 1);
    chk("R3 gated wraps", cnt_of(1), 32'hFFFF);
    ack();
    gate(2'b10, 1'b0);
    chk("R7 code 7", 32'(irq_code), 7);
    chk("R7 run cleared", 32'(run_o[1]), 0);
    ack();

    // R7 underflow on the same tick as the window closes
    dreset();
    wr(3'd4, 1, 16'h0006);
    wr(3'd2, 1, 16'd0);
    wr(3'd1, 0, 16'h0002);
    gate(2'b10, 1'b1);
    @(negedge clk); ext_gate = '0; ext_pulse = 2'b10;
    cyc(4); ext_pulse = '0; cyc(4);
    chk("R7 same-cycle code", 32'(irq_code), 7);
    ack();
    chk("R7 single request", 32'(irq_valid), 0);

    // R10 device reset
    wr(3'd4, 1, 16'h0002);
    wr(3'd2, 1, 16'd1000);
    wr(3'd1, 0, 16'h0001);
    wr(3'd2, 0, 16'd0);
    wr(3'd4, 0, 16'h0002);
    wr(3'd1, 0, 16'h0003);
    pulse(2'b01);
    chk("R10 pending before", 32'(irq_valid), 1);
    held = cnt_of(1);
    dreset();
    chk("R10 stopped", 32'(run_o), 0);
    chk("R10 request cleared", 32'(irq_valid), 0);
    cyc(3);
    chk("R10 count kept", cnt_of(1), held);
    wr(3'd1, 0, 16'h0002);
    chk("R10 enable kept", 32'(run_o[1]), 1);
    cyc(4 * DIV);
    chk("R10 mode cleared, internal ticks", 32'(cnt_of(1) < held), 1);
    wr(3'd1, 0, 16'h0008);

    // R11 system reset
    wr(3'd3, 0, 16'h0ABC);
    wr(3'd2, 0, 16'h0123);
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
    chk("R11 count kept", cnt_of(0), 32'h0123);
    wr(3'd1, 0, 16'h0001);
    chk("R11 enable cleared", 32'(run_o[0]), 0);
    wr(3'd0, 0, 16'h0001);
    wr(3'd4, 0, 16'h0003);
    wr(3'd2, 0, 16'd0);
    wr(3'd1, 0, 16'h0001);
    pulse(2'b01);
    chk("R11 reload kept", cnt_of(0), 32'h0ABC);
    chk("R4 still running", 32'(run_o[0]), 1);

    // R1 power-on reset sets reload registers to all ones
    @(negedge clk); por_n = 1'b0;
    cyc(2); por_n = 1'b1; cyc(1);
    chk("R1 cnt after por", cnt_of(0), 32'hFFFF);
    chk("R1 irq after por", 32'(irq_valid), 0);
    wr(3'd1, 0, 16'h0001);
    chk("R1 enable cleared", 32'(run_o[0]), 0);
    wr(3'd0, 0, 16'h0001);
    wr(3'd4, 0, 16'h0003);
    wr(3'd2, 0, 16'd0);
    wr(3'd1, 0, 16'h0001);
    pulse(2'b01);
    chk("R1 reload all ones", cnt_of(0), 32'hFFFF);
    chk("R1 running after reload", 32'(run_o[0]), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule